// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block is the serial core of an SPI master. Writing a byte while the engine is idle starts an 8-bit exchange at once. The byte goes out on the data output most-significant bit first. At the same time the data input is shifted in, also most-significant bit first. When the byte completes, the received value is copied into a receive buffer. The engine then raises a buffer-full status and an interrupt flag.

Three control inputs set the shape of the serial waveform:

- Clock polarity sets the idle level of the serial clock.
- Clock-edge select sets when each output bit is launched. With 1, the first bit is driven before the first clock edge. With 0, each bit is launched on a leading clock edge.
- Sample-point select sets when input data is captured: in the middle of the output bit time or at its end.

The bit clock has four possible sources: the system clock divided by 4, by 16 or by 64, or an external timer tick stream at half its rate.

The output driver can be switched off for receive-only use. In that mode the engine keeps clocking and delivers bytes, which allows line-activity monitoring.

Top module: `spi_master_engine`

## Requirements
- R1: A write strobe while the engine is idle and enabled starts a transfer with no other command. `busy_o` is 1 from the clock edge that takes the write until the transfer ends.
- R2: With `cke_i`=1, the MSB of the written byte appears on `sdo_o` in the first cycle after the write, before any clock edge. Each later bit is launched on a trailing clock edge (half-periods 2, 4, ... 14).
- R3: With `cke_i`=0, `sdo_o` stays 0 until the first clock edge. Bits are then launched MSB first on leading edges (half-periods 1, 3, ... 15).
- R4: `sck_o` idles at `cpol_i`. During a transfer it toggles exactly 16 times and then rests at the idle level.
- R5: Input bit k (k=0 is the MSB) is launched at half-period h = 2k plus 1 if `cke_i`=0. It is captured at half-period h+1 when `smp_i`=0 and at h+2 when `smp_i`=1. Bits are assembled MSB first.
- R6: `rate_sel_i` sets the half-period of the bit clock:
  - 0 gives 2 system clocks.
  - 1 gives 8 system clocks.
  - 2 gives 32 system clocks.
  - 3 gives one half-period per `tmr_tick_i` pulse.

  The divider restarts with every transfer.
- R7: A transfer ends after 16 half-periods, or after 17 when `cke_i`=0 and `smp_i`=1. On that same edge, `rd_data_o` takes the received byte, `buf_full_o` and `irq_o` become 1, and `busy_o` falls.
- R8: When `sdo_en_i`=0, `sdo_oe_o` and `sdo_o` are 0, and reception continues normally.
- R9: If `buf_full_o` is 1 when a byte completes, `ovf_o` becomes 1 and `rd_data_o` keeps its old value. `rd_i` clears `buf_full_o`.
- R10: A write during a transfer is ignored and sets `wcol_o`.
- R11: `irq_o`, `ovf_o` and `wcol_o` stay set until their clear strobes.
- R12: Changes to `cpol_i`, `cke_i`, `smp_i` and `rate_sel_i` during a transfer have no effect on it.
- R13: With `en_i`=0, writes are ignored. Any transfer in progress is abandoned, `sck_o` sits at `cpol_i` and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| cpol_i | input | 1 | Clock idle level |
| cke_i | input | 1 | 1: first bit valid before first edge; 0: launch on leading edges |
| smp_i | input | 1 | 0: capture mid bit; 1: capture at bit end |
| rate_sel_i | input | 2 | Bit clock source select |
| sdo_en_i | input | 1 | Output driver enable |
| tmr_tick_i | input | 1 | External timer tick pulse |
| wr_i | input | 1 | Write strobe, starts a transfer |
| wr_data_i | input | 8 | Byte to send |
| rd_i | input | 1 | Read strobe, clears buffer-full |
| irq_clr_i | input | 1 | Clears interrupt flag |
| ovf_clr_i | input | 1 | Clears overflow flag |
| wcol_clr_i | input | 1 | Clears write-collision flag |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output driver enable |
| busy_o | output | 1 | Transfer in progress |
| rd_data_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| irq_o | output | 1 | Byte-complete interrupt flag |
| ovf_o | output | 1 | Receive overflow flag |
| wcol_o | output | 1 | Write collision flag |

## Verification
Every result is tied to the clock edge that takes the write strobe. `busy_o` and the first `sdo_o` bit are due in the cycle right after it. Half-period n of the bit clock ends n half-periods after that edge, where a half-period is 2, 8 or 32 clocks, or one timer pulse. The buffer and the flags change on the same edge on which `busy_o` falls. The bench keeps its own half-period counter that advances by the same rule. In every cycle of a transfer it compares `sck_o`, `sdo_o` and `busy_o` on the falling clock edge with values computed from that counter. It drives `sdi_i` so that a capture one half-period early or late would pick up the wrong bit.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    RATE_DIV4  = 2'd0,
    RATE_DIV16 = 2'd1,
    RATE_DIV64 = 2'd2,
    RATE_TMR   = 2'd3
  } rate_e;

  typedef struct packed {
    logic  cpol;
    logic  cke;
    logic  smp;
    rate_e rate;
  } cfg_t;
endpackage

// File: rtl/spi_bit_clock.sv
module spi_bit_clock
  import spi_pkg::*;
#(
  parameter int unsigned HALF_FAST = 2,
  parameter int unsigned HALF_MID  = 8,
  parameter int unsigned HALF_SLOW = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  rate_e rate_i,
  input  logic  tmr_tick_i,
  output logic  tick_o
);
  localparam int unsigned CNT_W = $clog2(HALF_SLOW);

  logic [CNT_W-1:0] pc_q, half_m1;

  always_comb begin
    unique case (rate_i)
      RATE_DIV4:  half_m1 = CNT_W'(HALF_FAST - 1);
      RATE_DIV16: half_m1 = CNT_W'(HALF_MID - 1);
      RATE_DIV64: half_m1 = CNT_W'(HALF_SLOW - 1);
      default:    half_m1 = '0;
    endcase
  end

  assign tick_o = run_i && ((rate_i == RATE_TMR) ? tmr_tick_i : (pc_q == half_m1));

  // counter held in reset while idle: every transfer starts on a fresh phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            pc_q <= '0;
    else if (!run_i || rate_i == RATE_TMR)  pc_q <= '0;
    else if (tick_o)                        pc_q <= '0;
    else                                    pc_q <= pc_q + CNT_W'(1);
  end

  // R6
  pc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && rate_i != RATE_TMR |-> pc_q <= half_m1);

  // R6
  pc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pc_q == '0);
endmodule

// File: rtl/spi_shift_seq.sv
module spi_shift_seq
  import spi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  cfg_t              cfg_i,
  input  logic              tick_i,
  input  logic              sdi_i,
  output cfg_t              cfg_o,
  output logic              busy_o,
  output logic              tog_o,
  output logic              sdo_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int TC_W  = $clog2(EDGES + 2);

  cfg_t              cfg_q;
  logic              busy_q, tog_q, sdo_q;
  logic [TC_W-1:0]   tc_q, tc_n;
  logic [DATA_W-1:0] tx_q, rx_q, rx_n;
  logic              adv, launch, sample, toggle;
  int                loff, soff, end_tc;

  always_comb begin
    tc_n   = tc_q + TC_W'(1);
    adv    = busy_q && tick_i;
    loff   = int'(tc_n) - (cfg_q.cke ? 0 : 1);
    soff   = loff - 1 - (cfg_q.smp ? 1 : 0);
    // extra half-period only when launch is late and capture is at bit end
    end_tc = (cfg_q.cke || !cfg_q.smp) ? EDGES : EDGES + 1;
    launch = adv && loff >= 0 && loff[0] == 1'b0 && loff <= EDGES - 2;
    sample = adv && soff >= 0 && soff[0] == 1'b0 && soff <= EDGES - 2;
    toggle = adv && int'(tc_n) <= EDGES;
    done_o = adv && int'(tc_n) == end_tc;
    rx_n   = {rx_q[DATA_W-2:0], sdi_i};
    rx_o   = sample ? rx_n : rx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      sdo_q  <= 1'b0;
      tc_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      sdo_q  <= 1'b0;
      tc_q   <= '0;
    end else if (start_i) begin
      cfg_q  <= cfg_i;
      busy_q <= 1'b1;
      tog_q  <= 1'b0;
      tc_q   <= '0;
      rx_q   <= '0;
      if (cfg_i.cke) begin
        sdo_q <= wr_data_i[DATA_W-1];
        tx_q  <= {wr_data_i[DATA_W-2:0], 1'b0};
      end else begin
        tx_q  <= wr_data_i;
      end
    end else if (adv) begin
      tc_q <= tc_n;
      if (toggle) tog_q <= ~tog_q;
      if (launch) begin
        sdo_q <= tx_q[DATA_W-1];
        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
      end
      if (sample) rx_q <= rx_n;
      if (done_o) begin
        busy_q <= 1'b0;
        sdo_q  <= 1'b0;
        tc_q   <= '0;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = busy_q;
  assign tog_o  = tog_q;
  assign sdo_o  = sdo_q;

  // R1
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && en_i |=> busy_q);

  // R4
  sck_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !tog_q);

  // R7
  tc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> int'(tc_q) <= EDGES);

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(cfg_q));
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  input  logic              wcol_set_i,
  input  logic              wcol_clr_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              wcol_o
);
  logic [DATA_W-1:0] buf_q;
  logic              full_q, irq_q, ovf_q, wcol_q;
  logic              accept;

  assign accept = done_i && (!full_q || rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (accept) begin
        buf_q  <= data_i;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      if (done_i)         irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      if (done_i && !accept) ovf_q <= 1'b1;
      else if (ovf_clr_i)    ovf_q <= 1'b0;
      if (wcol_set_i)      wcol_q <= 1'b1;
      else if (wcol_clr_i) wcol_q <= 1'b0;
    end
  end

  assign buf_o  = buf_q;
  assign full_o = full_q;
  assign irq_o  = irq_q;
  assign ovf_o  = ovf_q;
  assign wcol_o = wcol_q;

  // R7
  done_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_q && full_q);

  // R9
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && full_q && !rd_i |=> ovf_q && buf_q == $past(buf_q));

  // R10
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcol_set_i |=> wcol_q);

  // R11
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !irq_clr_i |=> irq_q);
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HALF_FAST = 2,
  parameter int unsigned HALF_MID  = 8,
  parameter int unsigned HALF_SLOW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cke_i,
  input  logic              smp_i,
  input  logic [1:0]        rate_sel_i,
  input  logic              sdo_en_i,
  input  logic              tmr_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  input  logic              wcol_clr_i,
  input  logic              sdi_i,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              buf_full_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              wcol_o
);
  cfg_t              cfg_live, cfg_q;
  logic              busy, tog, sdo_raw, done, tick, start, wcol_set;
  logic [DATA_W-1:0] rx_data;

  assign cfg_live = '{cpol: cpol_i, cke: cke_i, smp: smp_i, rate: rate_e'(rate_sel_i)};
  assign start    = en_i && wr_i && !busy;
  assign wcol_set = en_i && wr_i && busy;

  spi_bit_clock #(
    .HALF_FAST(HALF_FAST), .HALF_MID(HALF_MID), .HALF_SLOW(HALF_SLOW)
  ) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .rate_i(cfg_q.rate),
    .tmr_tick_i(tmr_tick_i), .tick_o(tick)
  );

  spi_shift_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .start_i(start),
    .wr_data_i(wr_data_i), .cfg_i(cfg_live), .tick_i(tick), .sdi_i(sdi_i),
    .cfg_o(cfg_q), .busy_o(busy), .tog_o(tog), .sdo_o(sdo_raw),
    .done_o(done), .rx_o(rx_data)
  );

  spi_rx_status #(.DATA_W(DATA_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .data_i(rx_data),
    .rd_i(rd_i), .irq_clr_i(irq_clr_i), .ovf_clr_i(ovf_clr_i),
    .wcol_set_i(wcol_set), .wcol_clr_i(wcol_clr_i),
    .buf_o(rd_data_o), .full_o(buf_full_o), .irq_o(irq_o),
    .ovf_o(ovf_o), .wcol_o(wcol_o)
  );

  assign sck_o    = busy ? (cfg_q.cpol ^ tog) : cpol_i;
  assign sdo_oe_o = en_i && sdo_en_i;
  assign sdo_o    = sdo_raw && sdo_oe_o;
  assign busy_o   = busy;

  // R13
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o && !sdo_o);

  // R8
  rx_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_en_i |-> !sdo_o);
endmodule

// File: tb/spi_master_engine_tb.sv
`timescale 1ns/1ps
module spi_master_engine_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni, en_i, cpol_i, cke_i, smp_i, sdo_en_i, tmr_tick_i;
  logic [1:0] rate_sel_i;
  logic       wr_i, rd_i, irq_clr_i, ovf_clr_i, wcol_clr_i, sdi_i;
  logic [7:0] wr_data_i, rd_data_o;
  logic       sck_o, sdo_o, sdo_oe_o, busy_o, buf_full_o, irq_o, ovf_o, wcol_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  spi_master_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cpol_i(cpol_i), .cke_i(cke_i),
    .smp_i(smp_i), .rate_sel_i(rate_sel_i), .sdo_en_i(sdo_en_i),
    .tmr_tick_i(tmr_tick_i), .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_i(rd_i),
    .irq_clr_i(irq_clr_i), .ovf_clr_i(ovf_clr_i), .wcol_clr_i(wcol_clr_i),
    .sdi_i(sdi_i), .sck_o(sck_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .busy_o(busy_o), .rd_data_o(rd_data_o), .buf_full_o(buf_full_o),
    .irq_o(irq_o), .ovf_o(ovf_o), .wcol_o(wcol_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int half_of(input int r);
    case (r)
      0: return 2;
      1: return 8;
      2: return 32;
      default: return 1;
    endcase
  endfunction

  // one transfer, every cycle compared against the half-period count
  task automatic xfer(input bit pol, input bit ck, input bit sm, input int r,
                      input logic [7:0] tx, input logic [7:0] rx, input bit oe,
                      input bit inj_wcol, input bit inj_cfg, input string req);
    int t, n, endt, lead, hv, bad, bi, s, jj;
    bit tk, eb, es, ed;
    lead = ck ? 0 : 1;
    endt = (ck || !sm) ? 16 : 17;
    hv   = half_of(r);
    @(negedge clk_i);
    cpol_i = pol; cke_i = ck; smp_i = sm; rate_sel_i = 2'(r); sdo_en_i = oe;
    @(negedge clk_i);
    wr_i = 1'b1; wr_data_i = tx;
    @(posedge clk_i);
    t = 0; n = 0; bad = 0;
    forever begin
      @(negedge clk_i);
      wr_i = inj_wcol && n == 4;
      if (inj_wcol && n == 4) wr_data_i = ~tx;
      if (inj_cfg && n == 3) begin
        cke_i = !ck; smp_i = !sm; rate_sel_i = (r == 0) ? 2'd2 : 2'd0;
      end
      eb = t < endt;
      es = eb ? (pol ^ (((t < 16) ? t : 16) % 2 == 1)) : pol;
      if (!eb || !oe) ed = 1'b0;
      else begin
        bi = ck ? t / 2 : ((t == 0) ? -1 : (t - 1) / 2);
        if (bi > 7) bi = 7;
        ed = (bi < 0) ? 1'b0 : tx[7-bi];
      end
      if (busy_o !== eb || sck_o !== es || sdo_o !== ed || sdo_oe_o !== oe) begin
        if (bad == 0)
          $display("  mismatch t=%0d busy %b/%b sck %b/%b sdo %b/%b", t, busy_o, eb,
                   sck_o, es, sdo_o, ed);
        bad++;
      end
      if (t >= endt) break;
      s  = t - lead - (sm ? 1 : 0);
      jj = (s < 0) ? 0 : s / 2;
      if (jj > 7) jj = 7;
      sdi_i = rx[7-jj];
      tk = (r == 3) && (n % 3 == 2);
      tmr_tick_i = tk;
      @(posedge clk_i);
      n++;
      if (r == 3) begin
        if (tk) t++;
      end else if (n % hv == 0) t++;
    end
    tmr_tick_i = 1'b0; wr_i = 1'b0;
    cke_i = ck; smp_i = sm; rate_sel_i = 2'(r);
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic drain(input logic [7:0] rx, input string req);
    chk(rd_data_o == rx, req, rd_data_o, rx);
    chk(buf_full_o == 1'b1, "R7 full", buf_full_o, 1);
    chk(irq_o == 1'b1, "R7 irq", irq_o, 1);
    rd_i = 1'b1; irq_clr_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0; irq_clr_i = 1'b0;
    chk(buf_full_o == 1'b0, "R9 rd clears full", buf_full_o, 0);
    chk(irq_o == 1'b0, "R11 irq clear", irq_o, 0);
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] txv, rxv, rx_a;
    rst_ni = 1'b0; en_i = 1'b1; cpol_i = 1'b0; cke_i = 1'b1; smp_i = 1'b0;
    rate_sel_i = 2'd0; sdo_en_i = 1'b1; tmr_tick_i = 1'b0; wr_i = 1'b0;
    wr_data_i = '0; rd_i = 1'b0; irq_clr_i = 1'b0; ovf_clr_i = 1'b0;
    wcol_clr_i = 1'b0; sdi_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0 && sck_o == 1'b0 && sdo_o == 1'b0, "R4 reset idle",
        {busy_o, sck_o, sdo_o}, 0);
    chk({buf_full_o, irq_o, ovf_o, wcol_o} == 4'b0 && rd_data_o == 8'h00, "R11 reset flags",
        {buf_full_o, irq_o, ovf_o, wcol_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R3 R4 R5: all polarity / edge / sample combinations
    for (int m = 0; m < 8; m++) begin
      txv = 8'(8'h35 + m * 29);
      rxv = 8'(8'hC6 ^ (m * 37));
      xfer(m[2], m[1], m[0], 0, txv, rxv, 1'b1, 1'b0, 1'b0, "R1 R2 R3 R4 waveform");
      drain(rxv, "R5 rx byte");
    end

    // R6: other bit rates, timer source
    xfer(1'b0, 1'b1, 1'b0, 1, 8'hA5, 8'h5A, 1'b1, 1'b0, 1'b0, "R6 div16");
    drain(8'h5A, "R6 rx");
    xfer(1'b1, 1'b0, 1'b1, 2, 8'h81, 8'h7E, 1'b1, 1'b0, 1'b0, "R6 div64");
    drain(8'h7E, "R6 rx");
    xfer(1'b0, 1'b0, 1'b0, 3, 8'h3C, 8'hB2, 1'b1, 1'b0, 1'b0, "R6 timer");
    drain(8'hB2, "R6 rx");

    // R8 receive only
    xfer(1'b1, 1'b1, 1'b1, 0, 8'hFF, 8'h96, 1'b0, 1'b0, 1'b0, "R8 rx only waveform");
    drain(8'h96, "R8 rx only byte");

    // R10 write collision
    xfer(1'b0, 1'b1, 1'b0, 0, 8'h69, 8'h1D, 1'b1, 1'b1, 1'b0, "R10 write ignored");
    chk(wcol_o == 1'b1, "R10 wcol", wcol_o, 1);
    drain(8'h1D, "R10 rx unaffected");
    wcol_clr_i = 1'b1; @(negedge clk_i); wcol_clr_i = 1'b0;
    chk(wcol_o == 1'b0, "R11 wcol clear", wcol_o, 0);

    // R12 config changes mid transfer
    xfer(1'b1, 1'b0, 1'b0, 0, 8'hD4, 8'h2B, 1'b1, 1'b0, 1'b1, "R12 cfg latched");
    drain(8'h2B, "R12 rx");

    // R9 overflow
    rx_a = 8'h4E;
    xfer(1'b0, 1'b1, 1'b0, 0, 8'h11, rx_a, 1'b1, 1'b0, 1'b0, "R9 first byte");
    xfer(1'b0, 1'b1, 1'b0, 0, 8'h22, 8'hE1, 1'b1, 1'b0, 1'b0, "R9 second byte");
    chk(ovf_o == 1'b1, "R9 ovf", ovf_o, 1);
    chk(rd_data_o == rx_a, "R9 buffer kept", rd_data_o, rx_a);
    repeat (20) @(negedge clk_i);
    chk(ovf_o == 1'b1 && irq_o == 1'b1, "R11 sticky", {ovf_o, irq_o}, 3);
    ovf_clr_i = 1'b1; @(negedge clk_i); ovf_clr_i = 1'b0;
    chk(ovf_o == 1'b0, "R11 ovf clear", ovf_o, 0);
    drain(rx_a, "R9 buffer read");

    // R13 enable
    en_i = 1'b0; wr_i = 1'b1; wr_data_i = 8'hF0;
    @(negedge clk_i); wr_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b0 && wcol_o == 1'b0, "R13 write ignored", {busy_o, wcol_o}, 0);
    en_i = 1'b1; cpol_i = 1'b1; cke_i = 1'b1; wr_i = 1'b1; wr_data_i = 8'hFF;
    @(negedge clk_i); wr_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(busy_o == 1'b1, "R13 running", busy_o, 1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b0 && sck_o == 1'b1 && sdo_o == 1'b0, "R13 abort idle",
        {busy_o, sck_o, sdo_o}, 3'b010);
    en_i = 1'b1;
    xfer(1'b0, 1'b0, 1'b1, 0, 8'hC3, 8'h5B, 1'b1, 1'b0, 1'b0, "R13 recovery");
    drain(8'h5B, "R13 rx");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule